// File: doc/BRIEF.md
# Tree Up/Down Route Selector

This block makes the routing choice for one switch of a k-ary tree network. Each leaf address is a string of radix-k digits. The most significant digit is chosen nearest the root, and the least significant digit is chosen by the switch just above the leaves. A switch at level L, counting from 1 for the switches just above the leaves, is given the source and destination addresses of a packet header. It then decides one of three things: eject the packet locally, send it up toward the root, or send it down through a specific child port.

The decision does not use a table. The block XORs the two addresses and reduces the result to one "differs" flag per digit. It then finds the highest digit that differs, at index i. A packet must climb until it reaches a switch above level i, where i counts from 0 for the least significant digit. Switches at levels 1 to i send it up. Switches at levels i+1 and above send it down, and the child port is the destination digit that belongs to that level.

The result is held in one registered stage with valid/ready handshaking on both sides, so the block can sit in a switch's header path.

Top module: `tree_updown_router`

## Requirements
- R1: While reset is asserted and just after its release, out_valid is 0 and in_ready is 1.
- R2: A header accepted on a clock edge (in_valid and in_ready both 1) shows its result on the next edge with out_valid at 1.
- R3: When in_src equals in_dst, out_dir is LOCAL (code 0) and out_port is 0, at any sw_level.
- R4: Let i be the index of the highest digit in which in_src and in_dst differ, with digit d taken from address bits [d*log2(RADIX) +: log2(RADIX)]. When sw_level <= i, out_dir is UP (code 1) and out_port is 0.
- R5: When the addresses differ and sw_level > i, out_dir is DOWN (code 2) and out_port equals destination digit sw_level-1.
- R6: Distance is measured per digit, not per bit. For RADIX=4, addresses that differ only inside digit 0 give i = 0, even when bit 1 differs.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_dir and out_port hold their values.
- R8: in_ready is 0 while a result is stalled (out_valid 1, out_ready 0). A header offered during the stall is accepted on the edge where out_ready returns high, and its result replaces the stalled one on that edge.
- R9: If a result is taken (out_valid and out_ready both 1) and no header is accepted on the same edge, out_valid is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_level | input | $clog2(LEVELS+1) | Level of this switch, 1..LEVELS, held static |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Stage can take a header |
| in_src | input | LEVELS*log2(RADIX) | Source leaf address |
| in_dst | input | LEVELS*log2(RADIX) | Destination leaf address |
| out_valid | output | 1 | Routing result present |
| out_ready | input | 1 | Downstream takes the result |
| out_dir | output | 2 | 0 local, 1 up, 2 down |
| out_port | output | log2(RADIX) | Child port when going down, else 0 |

## Verification
Every routing result is due exactly one clock edge after the edge that accepts its header. The bench drives headers on the falling edge and waits for the next rising edge. It samples one time unit later, so each check sees the register that was loaded on that edge. During a stall the bench keeps sampling after every rising edge to confirm the output holds. The result of a header offered during the stall is checked one edge after out_ready rises. The fall of out_valid is checked one edge after the last result is taken with nothing new offered.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;
  typedef enum logic [1:0] {
    ROUTE_LOCAL = 2'd0,
    ROUTE_UP    = 2'd1,
    ROUTE_DOWN  = 2'd2
  } route_dir_e;
endpackage

// File: rtl/tree_digit_diff.sv
module tree_digit_diff #(
  parameter int RADIX  = 2,
  parameter int LEVELS = 4,
  localparam int DIGIT_W = $clog2(RADIX),
  localparam int ADDR_W  = LEVELS * DIGIT_W
) (
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic [LEVELS-1:0] digit_ne
);
  logic [ADDR_W-1:0] rel_addr;

  assign rel_addr = src ^ dst;

  for (genvar g = 0; g < LEVELS; g++) begin : g_digit
    assign digit_ne[g] = |rel_addr[g*DIGIT_W +: DIGIT_W];
  end
endmodule

// File: rtl/tree_lead_digit.sv
module tree_lead_digit #(
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS + 1)
) (
  input  logic [LEVELS-1:0] digit_ne,
  output logic              any_ne,
  output logic [LVL_W-1:0]  top_idx
);
  always_comb begin
    any_ne  = 1'b0;
    top_idx = '0;
    for (int g = 0; g < LEVELS; g++) begin
      if (digit_ne[g]) begin
        any_ne  = 1'b1;
        top_idx = LVL_W'(g);
      end
    end
  end
endmodule

// File: rtl/tree_port_pick.sv
module tree_port_pick
  import tree_route_pkg::*;
#(
  parameter int RADIX  = 2,
  parameter int LEVELS = 4,
  localparam int DIGIT_W = $clog2(RADIX),
  localparam int ADDR_W  = LEVELS * DIGIT_W,
  localparam int LVL_W   = $clog2(LEVELS + 1)
) (
  input  logic               any_ne,
  input  logic [LVL_W-1:0]   top_idx,
  input  logic [LVL_W-1:0]   sw_level,
  input  logic [ADDR_W-1:0]  dst,
  output route_dir_e         dir,
  output logic [DIGIT_W-1:0] port
);
  logic [DIGIT_W-1:0] level_digit;

  always_comb begin
    level_digit = '0;
    for (int g = 0; g < LEVELS; g++) begin
      if (sw_level == LVL_W'(g + 1)) level_digit = dst[g*DIGIT_W +: DIGIT_W];
    end
  end

  always_comb begin
    dir  = ROUTE_LOCAL;
    port = '0;
    if (any_ne) begin
      if (sw_level <= top_idx) begin
        dir = ROUTE_UP;
      end else begin
        dir  = ROUTE_DOWN;
        port = level_digit;
      end
    end
  end
endmodule

// File: rtl/tree_updown_router.sv
module tree_updown_router
  import tree_route_pkg::*;
#(
  parameter int RADIX  = 2,
  parameter int LEVELS = 4,
  localparam int DIGIT_W = $clog2(RADIX),
  localparam int ADDR_W  = LEVELS * DIGIT_W,
  localparam int LVL_W   = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   sw_level,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_src,
  input  logic [ADDR_W-1:0]  in_dst,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_dir,
  output logic [DIGIT_W-1:0] out_port
);
  logic [LEVELS-1:0]  digit_ne;
  logic               any_ne;
  logic [LVL_W-1:0]   top_idx;
  route_dir_e         pick_dir;
  logic [DIGIT_W-1:0] pick_port;

  logic               valid_q, valid_d;
  route_dir_e         dir_q, dir_d;
  logic [DIGIT_W-1:0] port_q, port_d;
  logic               load_en;

  tree_digit_diff #(.RADIX(RADIX), .LEVELS(LEVELS)) u_diff (
    .src      (in_src),
    .dst      (in_dst),
    .digit_ne (digit_ne)
  );

  tree_lead_digit #(.LEVELS(LEVELS)) u_lead (
    .digit_ne (digit_ne),
    .any_ne   (any_ne),
    .top_idx  (top_idx)
  );

  tree_port_pick #(.RADIX(RADIX), .LEVELS(LEVELS)) u_pick (
    .any_ne   (any_ne),
    .top_idx  (top_idx),
    .sw_level (sw_level),
    .dst      (in_dst),
    .dir      (pick_dir),
    .port     (pick_port)
  );

  assign in_ready = !valid_q || out_ready;
  assign load_en  = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    dir_d   = dir_q;
    port_d  = port_q;
    if (load_en) begin
      valid_d = 1'b1;
      dir_d   = pick_dir;
      port_d  = pick_port;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dir_q   <= ROUTE_LOCAL;
      port_q  <= '0;
    end else begin
      valid_q <= valid_d;
      dir_q   <= dir_d;
      port_q  <= port_d;
    end
  end

  assign out_valid = valid_q;
  assign out_dir   = dir_q;
  assign out_port  = port_q;
endmodule

// File: rtl/tree_updown_checker.sv
module tree_updown_checker #(
  parameter int RADIX  = 2,
  parameter int LEVELS = 4,
  localparam int DIGIT_W = $clog2(RADIX),
  localparam int ADDR_W  = LEVELS * DIGIT_W,
  localparam int LVL_W   = $clog2(LEVELS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LVL_W-1:0]   sw_level,
  input logic               in_valid,
  input logic               in_ready,
  input logic [ADDR_W-1:0]  in_src,
  input logic [ADDR_W-1:0]  in_dst,
  input logic               out_valid,
  input logic               out_ready,
  input logic [1:0]         out_dir,
  input logic [DIGIT_W-1:0] out_port
);
  logic [ADDR_W-1:0] src_anc, dst_anc;
  logic              take_hdr;

  always_comb begin
    src_anc  = in_src >> (DIGIT_W * 32'(sw_level));
    dst_anc  = in_dst >> (DIGIT_W * 32'(sw_level));
    take_hdr = in_valid && in_ready;
  end

  assert_result_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_hdr |=> out_valid);

  assert_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_hdr && (in_src == in_dst) |=> (out_dir == 2'd0) && (out_port == '0));

  assert_climb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_hdr && (src_anc != dst_anc) |=> (out_dir == 2'd1));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dir) && $stable(out_port));

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

bind tree_updown_router tree_updown_checker #(.RADIX(RADIX), .LEVELS(LEVELS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_level  (sw_level),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_src    (in_src),
  .in_dst    (in_dst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dir   (out_dir),
  .out_port  (out_port)
);

// File: tb/tree_updown_router_bench.sv
`timescale 1ns/1ps
module tree_updown_router_bench;
  logic clk, rst_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // binary 16-leaf instance (defaults)
  logic [2:0] b_lvl;
  logic       b_iv, b_ir, b_ov, b_or;
  logic [3:0] b_src, b_dst;
  logic [1:0] b_dir;
  logic [0:0] b_port;
  // radix-4 16-leaf instance
  logic [1:0] q_lvl;
  logic       q_iv, q_ir, q_ov, q_or;
  logic [3:0] q_src, q_dst;
  logic [1:0] q_dir;
  logic [1:0] q_port;

  tree_updown_router u_tree_updown_router (
    .clk(clk), .rst_n(rst_n), .sw_level(b_lvl), .in_valid(b_iv), .in_ready(b_ir),
    .in_src(b_src), .in_dst(b_dst), .out_valid(b_ov), .out_ready(b_or),
    .out_dir(b_dir), .out_port(b_port));

  tree_updown_router #(.RADIX(4), .LEVELS(2)) u_quad_router (
    .clk(clk), .rst_n(rst_n), .sw_level(q_lvl), .in_valid(q_iv), .in_ready(q_ir),
    .in_src(q_src), .in_dst(q_dst), .out_valid(q_ov), .out_ready(q_or),
    .out_dir(q_dir), .out_port(q_port));

  initial clk = 0;
  always #2.5 clk = ~clk;

  // {quad, src, dst, level, dir, port}
  localparam logic [15:0] VEC [8] = '{
    {1'b1, 4'h1, 4'h2, 3'd1, 2'd2, 2'd2},
    {1'b1, 4'h1, 4'h4, 3'd1, 2'd1, 2'd0},
    {1'b1, 4'h1, 4'h4, 3'd2, 2'd2, 2'd1},
    {1'b1, 4'h7, 4'h7, 3'd2, 2'd0, 2'd0},
    {1'b1, 4'h3, 4'h0, 3'd1, 2'd2, 2'd0},
    {1'b1, 4'h8, 4'hE, 3'd1, 2'd1, 2'd0},
    {1'b0, 4'h0, 4'hF, 3'd4, 2'd2, 2'd1},
    {1'b0, 4'h0, 4'hF, 3'd3, 2'd1, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Path-walk reference: go up while the switch's subtree lacks dst.
  function automatic void ref_route(input bit quad, input int s, input int d, input int lvl,
                                    output int dir, output int port);
    int dw = quad ? 2 : 1;
    port = 0;
    if (s == d) dir = 0;
    else if ((s >> (lvl*dw)) != (d >> (lvl*dw))) dir = 1;
    else begin
      dir  = 2;
      port = (d >> ((lvl-1)*dw)) & ((1 << dw) - 1);
    end
  endfunction

  task automatic send_check(input bit quad, input int s, input int d, input int lvl,
                            input int edir, input int eport);
    string req;
    int ad, ap, av;
    @(negedge clk);
    if (quad) begin q_iv = 1; q_src = 4'(s); q_dst = 4'(d); q_lvl = 2'(lvl); end
    else      begin b_iv = 1; b_src = 4'(s); b_dst = 4'(d); b_lvl = 3'(lvl); end
    @(posedge clk); #1;
    b_iv = 0; q_iv = 0;
    av = quad ? int'(q_ov) : int'(b_ov);
    ad = quad ? int'(q_dir) : int'(b_dir);
    ap = quad ? int'(q_port) : int'(b_port);
    req = (edir == 0) ? "R3" : (edir == 1) ? "R4" : "R5";
    if (quad) req = {req, "/R6"};
    chk(av == 1, "R2", "out_valid", av, 1);
    chk(ad == edir && ap == eport, req, $sformatf("dir*8+port s=%0d d=%0d l=%0d", s, d, lvl),
        ad*8 + ap, edir*8 + eport);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (completion)");
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ed, ep;
    rst_n = 0; b_iv = 0; q_iv = 0; b_or = 1; q_or = 1;
    b_src = 0; b_dst = 0; q_src = 0; q_dst = 0; b_lvl = 3'd1; q_lvl = 2'd1;
    repeat (3) @(posedge clk);
    #1;
    chk(b_ov == 0 && q_ov == 0, "R1", "out_valid in reset", int'(b_ov | q_ov), 0);
    chk(b_ir == 1 && q_ir == 1, "R1", "in_ready in reset", int'(b_ir & q_ir), 1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk(b_ov == 0, "R1", "out_valid after release", int'(b_ov), 0);

    // directed table
    for (int v = 0; v < 8; v++)
      send_check(VEC[v][15], int'(VEC[v][14:11]), int'(VEC[v][10:7]), int'(VEC[v][6:4]),
                 int'(VEC[v][3:2]), int'(VEC[v][1:0]));

    // exhaustive walks of both 16-leaf trees
    for (int l = 1; l <= 4; l++)
      for (int s = 0; s < 16; s++)
        for (int d = 0; d < 16; d++) begin
          ref_route(0, s, d, l, ed, ep);
          send_check(0, s, d, l, ed, ep);
        end
    for (int l = 1; l <= 2; l++)
      for (int s = 0; s < 16; s++)
        for (int d = 0; d < 16; d++) begin
          ref_route(1, s, d, l, ed, ep);
          send_check(1, s, d, l, ed, ep);
        end

    // drain: result taken, nothing new
    @(negedge clk); b_iv = 0;
    @(posedge clk); #1;
    chk(b_ov == 0, "R9", "out_valid after drain", int'(b_ov), 0);

    // stall: A = 0->5 at level 1 (up)
    @(negedge clk); b_or = 0; b_iv = 1; b_src = 4'd0; b_dst = 4'd5; b_lvl = 3'd1;
    @(posedge clk); #1;
    chk(b_ov == 1 && b_dir == 2'd1, "R2", "stalled result dir", int'(b_dir), 1);
    @(negedge clk); b_src = 4'd2; b_dst = 4'd3;   // B: down port 1
    #0.5;
    chk(b_ir == 0, "R8", "in_ready during stall", int'(b_ir), 0);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      chk(b_ov == 1 && b_dir == 2'd1 && b_port == 1'b0, "R7", "held dir*8+port",
          int'(b_dir)*8 + int'(b_port), 8);
    end
    @(negedge clk); b_or = 1;
    #0.5;
    chk(b_ir == 1, "R8", "in_ready on release", int'(b_ir), 1);
    @(posedge clk); #1;
    chk(b_ov == 1 && b_dir == 2'd2 && b_port == 1'b1, "R8", "stalled header result",
        int'(b_dir)*8 + int'(b_port), 17);
    @(negedge clk); b_iv = 0;
    @(posedge clk); #1;
    chk(b_ov == 0, "R9", "out_valid after last take", int'(b_ov), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule